// File: doc/BRIEF.md
# Flash Page DMA Engine

The engine moves one flash page between a local page buffer and system memory. The page is handled as two regions. The main data region always has a fixed size. The spare (out-of-band) region has a length that software programs. Each region has its own system-memory base address, and each can be enabled or skipped on its own. Software first writes the two base addresses, the spare length and the interrupt enables. It then writes a control word that carries the start bit, the direction, the enables for each region, the permitted burst sizes, a chip select and an address-format flag. The chip select and the address-format flag drive the flash sequencer outputs. The ECC computation and the flash bus timing are outside this block; the ECC results arrive as event pulses.

While a transfer runs, the start bit reads back as 1. The data region goes first and the spare region second. Each region is cut into bursts on a simple request/acknowledge memory port, and every acknowledge moves one beat. When the transfer ends, the start bit clears itself and a done flag is raised. The done flag and the two ECC flags can each raise the interrupt line through their own enable. Writing 1 to the matching bit of the clear register acknowledges a flag.

The controller walks through six named states:
- `ST_IDLE` goes to `ST_DATA_SEL` on an accepted start.
- `ST_DATA_SEL` loads the data region and goes to `ST_ISSUE`, or goes to `ST_SPARE_SEL` when the data region is disabled.
- `ST_SPARE_SEL` loads the spare region and goes to `ST_ISSUE`, or goes to `ST_FINISH` when the spare region is disabled or has zero length.
- `ST_ISSUE` picks the burst size and goes to `ST_XFER`.
- `ST_XFER` holds the request. After the last beat of a burst it returns to `ST_ISSUE`. After the last beat of a region it goes to `ST_SPARE_SEL` when the data region finished, or to `ST_FINISH` when the spare region finished.
- `ST_FINISH` raises the done event and returns to `ST_IDLE`.

Top module: `flash_page_dma`

## Requirements
- R1: After reset, every register reads 0, `irq` is low and `mem_req` is low.
- R2: Register word offsets on `reg_addr` are: 0 control, 1 data base, 2 spare base, 3 length, 4 interrupt enable, 5 interrupt status (read only), 6 interrupt clear (write only). The control bits are:
  - bit 0: start
  - bit 1: direction (1 = memory to buffer, toward the flash)
  - bit 2: data region enable
  - bit 3: spare region enable
  - bits 4, 5, 6: permit bursts of 4, 8 and 16 beats
  - bit 7: 4-cycle address format
  - bits 9:8: chip select

  Bits 9:1 read back as written. Bits 9:8 drive `flash_cs` and bit 7 drives `flash_addr4`.
- R3: Control bit 0 reads 1 from the cycle after an accepted start until completion. It clears on the same clock edge that sets interrupt status bit 9.
- R4: The data region (DATA_BYTES, from buffer beat 0, at the data base) is transferred completely before the spare region (from buffer beat DATA_BYTES/BEAT_BYTES, at the spare base). A disabled region is skipped. With neither region enabled, the transfer completes without any memory request.
- R5: The spare length is a byte count in length-register bits 27:16. The bits below one beat are ignored. The length is clamped to SPARE_BYTES. A length of zero skips the spare region.
- R6: Each burst uses the largest permitted size among 16, 8 and 4 that does not exceed the beats left in the region, and falls back to 1 beat otherwise.
- R7: `mem_req` stays high with a stable `mem_addr` (the burst start byte address) and `mem_beats` until the burst's last `mem_ack`. Each `mem_ack` moves one beat, and consecutive bursts are contiguous in memory.
- R8: With direction 0, `mem_write` is 1 and `mem_wdata` carries the buffer beat at `buf_addr`. With direction 1, `mem_write` is 0 and each acknowledged `mem_rdata` beat is written into the buffer through `buf_we`.
- R9: A control write while a transfer is active is ignored completely. It starts nothing and changes no control field.
- R10: Interrupt status bit 9 is done, bit 6 is the uncorrectable ECC error and bit 5 is the correctable ECC error. These bits sit at the same positions in the enable and clear registers. `irq` is high while any status bit and its enable bit are both 1.
- R11: Writing 1 to a bit of the clear register clears that status bit. If a set event arrives in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| ecc_corr | input | 1 | Correctable ECC error event pulse |
| ecc_uncorr | input | 1 | Uncorrectable ECC error event pulse |
| irq | output | 1 | Interrupt request |
| flash_cs | output | 2 | Chip select for the flash sequencer |
| flash_addr4 | output | 1 | 4-cycle address format for the flash sequencer |
| mem_req | output | 1 | Memory burst request |
| mem_write | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | ADDR_W | Burst start byte address |
| mem_beats | output | 5 | Beats in the current burst (1, 4, 8, 16) |
| mem_ack | input | 1 | One beat accepted or returned |
| mem_wdata | output | 8*BEAT_BYTES | Beat data toward memory |
| mem_rdata | input | 8*BEAT_BYTES | Beat data from memory |
| buf_addr | output | log2 of buffer beats | Page buffer beat index |
| buf_we | output | 1 | Page buffer write strobe |
| buf_wdata | output | 8*BEAT_BYTES | Page buffer write data |
| buf_rdata | input | 8*BEAT_BYTES | Page buffer read data (combinational) |

## Verification
Two functions of the interrupt flag logic can meet in one cycle: an ECC event pulse that sets a status flag, and a software clear of that same flag. The bench raises `ecc_corr` in exactly the cycle it writes 1 to clear bit 5, then reads the status register and expects the flag still set. A second clear on its own must then leave the flag at 0. Control writes that land during an active transfer are checked in the same way: the bench expects an unchanged readback and no extra memory beats.

// File: rtl/fpd_pkg.sv
package fpd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA_SEL,
        ST_SPARE_SEL,
        ST_ISSUE,
        ST_XFER,
        ST_FINISH
    } fpd_state_e;

    // register word offsets
    localparam logic [2:0] RA_CTRL  = 3'd0;
    localparam logic [2:0] RA_DBASE = 3'd1;
    localparam logic [2:0] RA_SBASE = 3'd2;
    localparam logic [2:0] RA_LEN   = 3'd3;
    localparam logic [2:0] RA_IEN   = 3'd4;
    localparam logic [2:0] RA_ISTAT = 3'd5;
    localparam logic [2:0] RA_ICLR  = 3'd6;

    // interrupt bit positions
    localparam int IB_CORR   = 5;
    localparam int IB_UNCORR = 6;
    localparam int IB_DONE   = 9;

    localparam int LEN_LO = 16;
    localparam int LEN_W  = 12;

    typedef struct packed {
        logic [1:0] cs;
        logic       addr4;
        logic [2:0] burst_ok;   // [0]=4, [1]=8, [2]=16 beats
        logic       spare_en;
        logic       data_en;
        logic       to_flash;
    } fpd_cfg_t;

endpackage

// File: rtl/fpd_regs.sv
module fpd_regs
    import fpd_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              busy,
    input  logic              done_evt,
    input  logic              corr_evt,
    input  logic              uncorr_evt,
    output logic              start_pulse,
    output fpd_cfg_t          cfg,
    output logic [ADDR_W-1:0] data_base,
    output logic [ADDR_W-1:0] spare_base,
    output logic [LEN_W-1:0]  spare_len,
    output logic              irq
);

    logic [9:1] ctrl_q;
    logic [2:0] stat_q;   // {done, uncorr, corr}
    logic [2:0] ien_q;
    logic [2:0] set_v;
    logic [2:0] clr_v;
    logic       ctrl_wr;

    assign ctrl_wr     = reg_we && (reg_addr == RA_CTRL);
    assign start_pulse = ctrl_wr && reg_wdata[0] && !busy;
    assign set_v       = {done_evt, uncorr_evt, corr_evt};
    assign clr_v       = (reg_we && reg_addr == RA_ICLR) ?
                         {reg_wdata[IB_DONE], reg_wdata[IB_UNCORR], reg_wdata[IB_CORR]} : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            ien_q      <= '0;
            data_base  <= '0;
            spare_base <= '0;
            spare_len  <= '0;
        end else begin
            if (ctrl_wr && !busy) ctrl_q <= reg_wdata[9:1];
            if (reg_we && reg_addr == RA_DBASE) data_base  <= reg_wdata[ADDR_W-1:0];
            if (reg_we && reg_addr == RA_SBASE) spare_base <= reg_wdata[ADDR_W-1:0];
            if (reg_we && reg_addr == RA_LEN)   spare_len  <= reg_wdata[LEN_LO +: LEN_W];
            if (reg_we && reg_addr == RA_IEN)
                ien_q <= {reg_wdata[IB_DONE], reg_wdata[IB_UNCORR], reg_wdata[IB_CORR]};
            stat_q <= (stat_q & ~clr_v) | set_v;
        end
    end

    assign cfg.to_flash = ctrl_q[1];
    assign cfg.data_en  = ctrl_q[2];
    assign cfg.spare_en = ctrl_q[3];
    assign cfg.burst_ok = ctrl_q[6:4];
    assign cfg.addr4    = ctrl_q[7];
    assign cfg.cs       = ctrl_q[9:8];

    assign irq = |(stat_q & ien_q);

    function automatic logic [31:0] place_irq(input logic [2:0] v);
        logic [31:0] r;
        r = '0;
        r[IB_CORR]   = v[0];
        r[IB_UNCORR] = v[1];
        r[IB_DONE]   = v[2];
        return r;
    endfunction

    always_comb begin
        unique case (reg_addr)
            RA_CTRL:  reg_rdata = {22'b0, ctrl_q, busy};
            RA_DBASE: reg_rdata = 32'(data_base);
            RA_SBASE: reg_rdata = 32'(spare_base);
            RA_LEN:   reg_rdata = 32'(spare_len) << LEN_LO;
            RA_IEN:   reg_rdata = place_irq(ien_q);
            RA_ISTAT: reg_rdata = place_irq(stat_q);
            default:  reg_rdata = '0;
        endcase
    end

    // R9
    ctrl_busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && busy) |=> $stable(ctrl_q));

    // R11
    corr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        corr_evt |=> stat_q[0]);

    // R3
    done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> stat_q[2]);

endmodule

// File: rtl/fpd_burst_pick.sv
module fpd_burst_pick #(
    parameter int CNT_W = 10
) (
    input  logic [CNT_W-1:0] rem,
    input  logic [2:0]       burst_ok,
    output logic [4:0]       beats
);

    always_comb begin
        if (burst_ok[2] && rem >= CNT_W'(16))      beats = 5'd16;
        else if (burst_ok[1] && rem >= CNT_W'(8))  beats = 5'd8;
        else if (burst_ok[0] && rem >= CNT_W'(4))  beats = 5'd4;
        else                                       beats = 5'd1;
    end

endmodule

// File: rtl/fpd_engine.sv
module fpd_engine
    import fpd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BEAT_BYTES  = 4,
    parameter int DATA_BEATS  = 512,
    parameter int SPARE_BEATS = 32,
    parameter int BUF_AW      = 10,
    parameter int CNT_W       = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_pulse,
    input  logic              to_flash,
    input  logic              data_en,
    input  logic              spare_en,
    input  logic [2:0]        burst_ok,
    input  logic [ADDR_W-1:0] data_base,
    input  logic [ADDR_W-1:0] spare_base,
    input  logic [LEN_W-1:0]  spare_len,
    output logic              busy,
    output logic              done_evt,
    output logic              mem_req,
    output logic              mem_write,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [4:0]        mem_beats,
    input  logic              mem_ack,
    output logic [BUF_AW-1:0] buf_addr,
    output logic              buf_we
);

    localparam int BEAT_SHIFT = $clog2(BEAT_BYTES);

    fpd_state_e        state_q, state_d;
    logic              region_q;   // 0 data, 1 spare
    logic [CNT_W-1:0]  rem_q;
    logic [4:0]        left_q;
    logic [4:0]        burst_q;
    logic [4:0]        pick;
    logic [ADDR_W-1:0] maddr_q;
    logic [BUF_AW-1:0] baddr_q;
    logic [LEN_W-1:0]  len_beats;
    logic [CNT_W-1:0]  spare_beats;
    logic              spare_go;
    logic              last_beat;

    assign len_beats   = spare_len >> BEAT_SHIFT;
    assign spare_beats = (len_beats > LEN_W'(SPARE_BEATS)) ? CNT_W'(SPARE_BEATS) : CNT_W'(len_beats);
    assign spare_go    = spare_en && (spare_beats != '0);
    assign last_beat   = mem_ack && (left_q == 5'd1);

    fpd_burst_pick #(.CNT_W(CNT_W)) u_pick (
        .rem      (rem_q),
        .burst_ok (burst_ok),
        .beats    (pick)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_pulse) state_d = ST_DATA_SEL;
            ST_DATA_SEL:  state_d = data_en ? ST_ISSUE : ST_SPARE_SEL;
            ST_SPARE_SEL: state_d = spare_go ? ST_ISSUE : ST_FINISH;
            ST_ISSUE:     state_d = ST_XFER;
            ST_XFER: begin
                if (last_beat) begin
                    if (rem_q == CNT_W'(1)) state_d = region_q ? ST_FINISH : ST_SPARE_SEL;
                    else                    state_d = ST_ISSUE;
                end
            end
            ST_FINISH:    state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy      = (state_q != ST_IDLE);
        done_evt  = (state_q == ST_FINISH);
        mem_req   = (state_q == ST_XFER);
        mem_write = !to_flash;
        mem_addr  = maddr_q;
        mem_beats = burst_q;
        buf_addr  = baddr_q;
        buf_we    = (state_q == ST_XFER) && mem_ack && to_flash;
    end

    // address generator
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            region_q <= 1'b0;
            rem_q    <= '0;
            left_q   <= '0;
            burst_q  <= '0;
            maddr_q  <= '0;
            baddr_q  <= '0;
        end else begin
            unique case (state_q)
                ST_DATA_SEL: if (data_en) begin
                    region_q <= 1'b0;
                    rem_q    <= CNT_W'(DATA_BEATS);
                    maddr_q  <= data_base;
                    baddr_q  <= '0;
                end
                ST_SPARE_SEL: if (spare_go) begin
                    region_q <= 1'b1;
                    rem_q    <= spare_beats;
                    maddr_q  <= spare_base;
                    baddr_q  <= BUF_AW'(DATA_BEATS);
                end
                ST_ISSUE: begin
                    burst_q <= pick;
                    left_q  <= pick;
                end
                ST_XFER: if (mem_ack) begin
                    rem_q   <= rem_q - CNT_W'(1);
                    left_q  <= left_q - 5'd1;
                    baddr_q <= baddr_q + BUF_AW'(1);
                    if (left_q == 5'd1)
                        maddr_q <= maddr_q + (ADDR_W'(burst_q) << BEAT_SHIFT);
                end
                default: ;
            endcase
        end
    end

    // R7
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_beats)));

    // R6
    burst_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_beats == 5'd1 || (mem_beats == 5'd4 && burst_ok[0]) ||
                     (mem_beats == 5'd8 && burst_ok[1]) || (mem_beats == 5'd16 && burst_ok[2])));

    // R6
    burst_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER) |-> (CNT_W'(left_q) <= rem_q));

    // R4
    region_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_XFER && region_q) |=> !(state_q == ST_XFER && !region_q));

endmodule

// File: rtl/flash_page_dma.sv
module flash_page_dma
    import fpd_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int BEAT_BYTES  = 4,
    parameter int DATA_BYTES  = 2048,
    parameter int SPARE_BYTES = 128
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          reg_we,
    input  logic [2:0]                    reg_addr,
    input  logic [31:0]                   reg_wdata,
    output logic [31:0]                   reg_rdata,
    input  logic                          ecc_corr,
    input  logic                          ecc_uncorr,
    output logic                          irq,
    output logic [1:0]                    flash_cs,
    output logic                          flash_addr4,
    output logic                          mem_req,
    output logic                          mem_write,
    output logic [ADDR_W-1:0]             mem_addr,
    output logic [4:0]                    mem_beats,
    input  logic                          mem_ack,
    output logic [8*BEAT_BYTES-1:0]       mem_wdata,
    input  logic [8*BEAT_BYTES-1:0]       mem_rdata,
    output logic [$clog2((DATA_BYTES+SPARE_BYTES)/BEAT_BYTES)-1:0] buf_addr,
    output logic                          buf_we,
    output logic [8*BEAT_BYTES-1:0]       buf_wdata,
    input  logic [8*BEAT_BYTES-1:0]       buf_rdata
);

    localparam int DATA_BEATS  = DATA_BYTES / BEAT_BYTES;
    localparam int SPARE_BEATS = SPARE_BYTES / BEAT_BYTES;
    localparam int BUF_AW      = $clog2(DATA_BEATS + SPARE_BEATS);
    localparam int CNT_W       = $clog2(DATA_BEATS + 1);

    fpd_cfg_t          cfg;
    logic              start_pulse;
    logic              busy;
    logic              done_evt;
    logic [ADDR_W-1:0] data_base;
    logic [ADDR_W-1:0] spare_base;
    logic [LEN_W-1:0]  spare_len;

    fpd_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .busy        (busy),
        .done_evt    (done_evt),
        .corr_evt    (ecc_corr),
        .uncorr_evt  (ecc_uncorr),
        .start_pulse (start_pulse),
        .cfg         (cfg),
        .data_base   (data_base),
        .spare_base  (spare_base),
        .spare_len   (spare_len),
        .irq         (irq)
    );

    fpd_engine #(
        .ADDR_W      (ADDR_W),
        .BEAT_BYTES  (BEAT_BYTES),
        .DATA_BEATS  (DATA_BEATS),
        .SPARE_BEATS (SPARE_BEATS),
        .BUF_AW      (BUF_AW),
        .CNT_W       (CNT_W)
    ) u_engine (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_pulse (start_pulse),
        .to_flash    (cfg.to_flash),
        .data_en     (cfg.data_en),
        .spare_en    (cfg.spare_en),
        .burst_ok    (cfg.burst_ok),
        .data_base   (data_base),
        .spare_base  (spare_base),
        .spare_len   (spare_len),
        .busy        (busy),
        .done_evt    (done_evt),
        .mem_req     (mem_req),
        .mem_write   (mem_write),
        .mem_addr    (mem_addr),
        .mem_beats   (mem_beats),
        .mem_ack     (mem_ack),
        .buf_addr    (buf_addr),
        .buf_we      (buf_we)
    );

    assign flash_cs    = cfg.cs;
    assign flash_addr4 = cfg.addr4;
    assign mem_wdata   = buf_rdata;
    assign buf_wdata   = mem_rdata;

endmodule

// File: tb/test_flash_page_dma.sv
module test_flash_page_dma;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        ecc_corr = 1'b0;
    logic        ecc_uncorr = 1'b0;
    logic        irq;
    logic [1:0]  flash_cs;
    logic        flash_addr4;
    logic        mem_req;
    logic        mem_write;
    logic [31:0] mem_addr;
    logic [4:0]  mem_beats;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic [9:0]  buf_addr;
    logic        buf_we;
    logic [31:0] buf_wdata;
    logic [31:0] buf_rdata;

    always #2 clk = ~clk;

    flash_page_dma i_flash_page_dma (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ecc_corr(ecc_corr),
        .ecc_uncorr(ecc_uncorr), .irq(irq), .flash_cs(flash_cs),
        .flash_addr4(flash_addr4), .mem_req(mem_req), .mem_write(mem_write),
        .mem_addr(mem_addr), .mem_beats(mem_beats), .mem_ack(mem_ack),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .buf_addr(buf_addr),
        .buf_we(buf_we), .buf_wdata(buf_wdata), .buf_rdata(buf_rdata)
    );

    int checks = 0;
    int fails  = 0;
    bit all_done = 0;

    task automatic chk(input bit ok, input string what, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic logic [31:0] bpat(input int i);
        return 32'h5A00_0000 + 32'(i) * 32'd7;
    endfunction

    function automatic logic [31:0] mpat(input logic [31:0] a);
        return a ^ 32'h3C3C_0000;
    endfunction

    // page buffer model: reads follow a pattern, writes land in bmem
    logic [31:0] bmem [0:543];
    int nbuf_wr = 0;
    assign buf_rdata = bpat(int'(buf_addr));
    always @(posedge clk) begin
        if (buf_we) begin
            if (buf_addr < 10'd544) bmem[buf_addr] <= buf_wdata;
            nbuf_wr <= nbuf_wr + 1;
        end
    end

    // scoreboard
    typedef struct {
        logic [31:0] addr;
        logic [4:0]  beats;
        logic [31:0] data;
        logic        wr;
    } beat_t;
    beat_t exp_q[$];

    task automatic push_region(input logic [31:0] base, input int bidx, input int n,
                               input logic [2:0] ok, input logic wr);
        int left = n;
        int k = 0;
        while (left > 0) begin
            int b;
            if (ok[2] && left >= 16) b = 16;
            else if (ok[1] && left >= 8) b = 8;
            else if (ok[0] && left >= 4) b = 4;
            else b = 1;
            for (int j = 0; j < b; j++) begin
                beat_t it;
                it.addr  = base + 32'((k + j) * 4);
                it.beats = 5'(b);
                it.data  = bpat(bidx + k + j);
                it.wr    = wr;
                exp_q.push_back(it);
            end
            k += b;
            left -= b;
        end
    endtask

    // memory model and monitor
    int idx = 0;
    int cur_beats = 1;
    int stall = 0;
    bit stall_on = 1;
    always @(negedge clk) begin
        if (mem_ack) begin
            idx = idx + 1;
            if (idx == cur_beats) idx = 0;
        end
        stall = stall + 1;
        if (rst_n && mem_req && (!stall_on || (stall % 3) != 0)) begin
            logic [31:0] ba;
            cur_beats = int'(mem_beats);
            ba = mem_addr + 32'(idx * 4);
            mem_rdata = mpat(ba);
            if (exp_q.size() == 0) begin
                chk(0, "R4 unexpected memory beat", ba, 0);
            end else begin
                beat_t e;
                e = exp_q.pop_front();
                chk(ba == e.addr, "R7 beat address", ba, e.addr);
                chk(mem_beats == e.beats, "R6 burst size", mem_beats, e.beats);
                chk(mem_write == e.wr, "R8 memory direction", mem_write, e.wr);
                if (e.wr) chk(mem_wdata == e.data, "R8 beat data to memory", mem_wdata, e.data);
            end
            mem_ack = 1'b1;
        end else begin
            mem_ack = 1'b0;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] v;
        int n = 0;
        do begin
            rd(3'd0, v);
            n++;
        end while (v[0] && n < 5000);
        chk(!v[0], {tag, " start bit self-clears"}, v[0], 0);
        chk(exp_q.size() == 0, {tag, " all expected beats seen"}, exp_q.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        if (!all_done) begin
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        int base_wr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(3'd0, v); chk(v == 0, "R1 control after reset", v, 0);
        rd(3'd5, v); chk(v == 0, "R1 status after reset", v, 0);
        chk(irq == 0, "R1 irq after reset", irq, 0);
        chk(mem_req == 0, "R1 mem_req after reset", mem_req, 0);

        // data region, buffer to memory, all bursts
        wr(3'd1, 32'h1000_0000);
        wr(3'd4, 32'h0000_0200);
        push_region(32'h1000_0000, 0, 512, 3'b111, 1'b1);
        wr(3'd0, 32'h0000_02F5);
        rd(3'd0, v); chk(v[0] == 1, "R3 start reads 1 while active", v[0], 1);
        chk(flash_cs == 2'd2, "R2 chip select output", flash_cs, 2);
        chk(flash_addr4 == 1, "R2 address format output", flash_addr4, 1);
        wait_idle("R4 data only");
        rd(3'd0, v); chk(v == 32'h2F4, "R2 control readback", v, 32'h2F4);
        rd(3'd5, v); chk(v == 32'h200, "R3 done flag set", v, 32'h200);
        chk(irq == 1, "R10 irq from enabled done", irq, 1);
        wr(3'd6, 32'h200);
        rd(3'd5, v); chk(v == 0, "R11 clear done", v, 0);
        chk(irq == 0, "R10 irq drops after clear", irq, 0);

        // spare only, 40 bytes, bursts of 8 and 4: 8 then 1,1; ignored start while busy
        wr(3'd2, 32'h2000_0040);
        wr(3'd3, 32'd40 << 16);
        push_region(32'h2000_0040, 512, 10, 3'b011, 1'b1);
        wr(3'd0, 32'h0000_0039);
        wr(3'd0, 32'h0000_0307);
        rd(3'd0, v); chk(v == 32'h39, "R9 control unchanged by busy write", v, 32'h39);
        chk(flash_cs == 0, "R9 chip select unchanged", flash_cs, 0);
        wait_idle("R6 spare bursts");
        repeat (20) @(negedge clk);
        chk(mem_req == 0, "R9 no second transfer", mem_req, 0);
        chk(exp_q.size() == 0, "R9 no extra beats", exp_q.size(), 0);
        wr(3'd6, 32'h200);

        // both regions, memory to buffer, singles only, spare 12 bytes
        wr(3'd1, 32'h3000_0000);
        wr(3'd2, 32'h3000_8000);
        wr(3'd3, 32'd12 << 16);
        push_region(32'h3000_0000, 0, 512, 3'b000, 1'b0);
        push_region(32'h3000_8000, 512, 3, 3'b000, 1'b0);
        base_wr = nbuf_wr;
        stall_on = 0;
        wr(3'd0, 32'h0000_000F);
        wait_idle("R4 both regions");
        stall_on = 1;
        chk(nbuf_wr - base_wr == 515, "R8 buffer write count", nbuf_wr - base_wr, 515);
        begin
            int bad = 0;
            for (int i = 0; i < 512; i++)
                if (bmem[i] !== mpat(32'h3000_0000 + 32'(i * 4))) bad++;
            for (int i = 0; i < 3; i++)
                if (bmem[512 + i] !== mpat(32'h3000_8000 + 32'(i * 4))) bad++;
            chk(bad == 0, "R8 buffer contents from memory", bad, 0);
        end
        wr(3'd6, 32'h200);

        // spare clamp: 4095 bytes -> 32 beats
        wr(3'd2, 32'h4000_0000);
        wr(3'd3, 32'h0FFF_0000);
        push_region(32'h4000_0000, 512, 32, 3'b100, 1'b1);
        wr(3'd0, 32'h0000_0049);
        wait_idle("R5 clamp");

        // spare 10 bytes -> 2 beats, burst of 4 does not fit
        wr(3'd3, 32'd10 << 16);
        push_region(32'h4000_0000, 512, 2, 3'b001, 1'b1);
        wr(3'd0, 32'h0000_0019);
        wait_idle("R5 partial beat");

        // neither region enabled
        wr(3'd6, 32'h200);
        wr(3'd0, 32'h0000_0041);
        wait_idle("R4 no region");
        rd(3'd5, v); chk(v == 32'h200, "R4 empty transfer completes", v, 32'h200);

        // spare enabled with zero length
        wr(3'd6, 32'h200);
        wr(3'd3, 32'h0);
        wr(3'd0, 32'h0000_0009);
        wait_idle("R5 zero length");
        rd(3'd5, v); chk(v == 32'h200, "R5 zero length completes", v, 32'h200);
        wr(3'd6, 32'h200);

        // interrupt gating and set-wins
        wr(3'd4, 32'h0);
        @(negedge clk); ecc_corr = 1'b1; @(negedge clk); ecc_corr = 1'b0;
        rd(3'd5, v); chk(v == 32'h20, "R10 correctable flag", v, 32'h20);
        chk(irq == 0, "R10 irq gated by enable", irq, 0);
        wr(3'd4, 32'h20);
        chk(irq == 1, "R10 irq with enable", irq, 1);
        @(negedge clk);
        ecc_corr = 1'b1; reg_we = 1'b1; reg_addr = 3'd6; reg_wdata = 32'h20;
        @(negedge clk);
        ecc_corr = 1'b0; reg_we = 1'b0;
        rd(3'd5, v); chk(v == 32'h20, "R11 set wins over clear", v, 32'h20);
        wr(3'd6, 32'h20);
        rd(3'd5, v); chk(v == 0, "R11 clear alone", v, 0);
        @(negedge clk); ecc_uncorr = 1'b1; @(negedge clk); ecc_uncorr = 1'b0;
        rd(3'd5, v); chk(v == 32'h40, "R10 uncorrectable flag", v, 32'h40);
        chk(irq == 0, "R10 uncorrectable gated", irq, 0);
        wr(3'd4, 32'h40);
        chk(irq == 1, "R10 uncorrectable irq", irq, 1);

        all_done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule